// File: doc/BRIEF.md
# Intra 16x16 Fill Predictor

This block builds a 16x16 array of 8-bit predicted samples for three of the intra modes used by block-based video coders: vertical copy, horizontal copy and flat (DC) fill. A start pulse captures the sixteen samples above the block, the sixteen samples to its left, a 2-bit mode code and two flags that say whether the upper and the left neighbours exist. The block then streams the prediction one row per cycle. Each row is 16 packed bytes and comes with a valid strobe, a row index and a last-row marker.

For flat fill, the block adds up the neighbours that are present, rounds the sum and divides it down to one sample value. The divisor and the rounding constant depend on how many neighbour sets are present. When no neighbour is present the fill value is mid-grey. Plane prediction, code 3, is left to another unit. A start with that code only raises a one-cycle flag.

Top module: `intra_fill16`

## Requirements
- R1: In vertical mode (code 0), every output row equals the captured upper samples. Column x of a row sits at bits [8x+7:8x], and upper sample x is taken from the same bits of `aboveRow`.
- R2: In horizontal mode (code 1), every byte of row y equals captured left sample y. Left sample y is read from bits [8y+7:8y] of `leftCol`.
- R3: In DC mode (code 2) with both `upperOk` and `leftOk` high, all 256 samples equal (sum of the 16 upper samples + sum of the 16 left samples + 16) >> 5.
- R4: In DC mode with exactly one of the two flags high, all samples equal (sum of that side's 16 samples + 8) >> 4. The other side's samples have no effect.
- R5: In DC mode with both flags low, all samples equal 128, whatever the neighbour values are.
- R6: After a start that is accepted, rows 0 to 15 come out on 16 consecutive cycles, starting the cycle after the start edge. `rowIdx` counts up from 0, and `rowLast` is high only with row 15.
- R7: A start with mode code 3 makes `badMode` high for the next cycle and produces no rows.
- R8: Neighbour samples, mode and flags are captured at the start edge. Changes to them while rows are streaming do not change the rows.
- R9: A start that arrives while rows are streaming is ignored. The run still ends after row 15 and `rowValid` falls on the next cycle.
- R10: After reset, `rowValid`, `rowLast` and `badMode` are low.
- R11: The sums cannot overflow. Thirty-two samples of 255 with both flags set give a DC value of 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a prediction; sampled only when idle |
| mode | input | 2 | 0 vertical, 1 horizontal, 2 DC, 3 plane (rejected) |
| upperOk | input | 1 | Upper neighbour samples are present |
| leftOk | input | 1 | Left neighbour samples are present |
| aboveRow | input | 128 | Sixteen upper samples, sample x at [8x+7:8x] |
| leftCol | input | 128 | Sixteen left samples, sample y at [8y+7:8y] |
| rowValid | output | 1 | A predicted row is on rowData |
| rowIdx | output | 4 | Index of the row on rowData |
| rowLast | output | 1 | The row on rowData is row 15 |
| rowData | output | 128 | Sixteen predicted samples, column x at [8x+7:8x] |
| badMode | output | 1 | One-cycle pulse after a start with code 3 |

## Verification
A corrupted row counter appears within one cycle as a skipped or repeated `rowIdx`, a stray `rowLast`, or a run whose length is not 16. A wrong captured mode or flag appears on the first row as the wrong pattern, and every row after it shares the error. A faulty adder or shift shows up only in DC mode. The flat-fill value is therefore checked with each flag combination and with saturating inputs. Capture errors are exposed by changing the inputs during the run, so that a block which reads its inputs live instead of the captured copy fails on row 0.

// File: rtl/intra_fill_pkg.sv
package intra_fill_pkg;
  parameter int GRID_N = 16;
  localparam int ROW_W = $clog2(GRID_N);

  typedef enum logic [1:0] {
    MODE_VERT  = 2'd0,
    MODE_HORZ  = 2'd1,
    MODE_DC    = 2'd2,
    MODE_PLANE = 2'd3
  } predMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             latch;
    logic [ROW_W-1:0] row;
  } fillStrobe_t;
endpackage

// File: rtl/intra_fill_ctrl.sv
module intra_fill_ctrl
  import intra_fill_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       mode,
  output fillStrobe_t      stb,
  output logic             rowValid,
  output logic [ROW_W-1:0] rowIdx,
  output logic             rowLast,
  output logic             badMode
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(GRID_N - 1);

  ctrlState_e       state;
  logic [ROW_W-1:0] rowCnt;
  logic             badQ;
  logic             idle;
  logic             accept;

  assign idle   = (state == ST_IDLE);
  assign accept = idle && start && (mode != MODE_PLANE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rowCnt <= '0;
      badQ   <= 1'b0;
    end else begin
      badQ <= idle && start && (mode == MODE_PLANE);
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_RUN;
            rowCnt <= '0;
          end
        end
        default: begin
          if (rowCnt == LAST_ROW) begin
            state <= ST_IDLE;
          end else begin
            rowCnt <= rowCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign stb.latch = accept;
  assign stb.row   = rowCnt;
  assign rowValid  = (state == ST_RUN);
  assign rowIdx    = rowCnt;
  assign rowLast   = (state == ST_RUN) && (rowCnt == LAST_ROW);
  assign badMode   = badQ;
endmodule

// File: rtl/intra_fill_dp.sv
module intra_fill_dp
  import intra_fill_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fillStrobe_t                  stb,
  input  logic [1:0]                   modeIn,
  input  logic                         upperIn,
  input  logic                         leftIn,
  input  logic [GRID_N*SAMPLE_W-1:0]   aboveIn,
  input  logic [GRID_N*SAMPLE_W-1:0]   leftColIn,
  output logic [GRID_N*SAMPLE_W-1:0]   rowData
);
  localparam int LINE_W = GRID_N * SAMPLE_W;
  localparam int LOG_N  = $clog2(GRID_N);
  localparam int SUM_W  = SAMPLE_W + $clog2(2 * GRID_N);

  logic [LINE_W-1:0]   aboveQ;
  logic [LINE_W-1:0]   leftQ;
  logic [1:0]          modeQ;
  logic                upQ;
  logic                lfQ;
  logic [SUM_W-1:0]    sumAbove;
  logic [SUM_W-1:0]    sumLeft;
  logic [SAMPLE_W-1:0] dcVal;
  logic [SAMPLE_W-1:0] leftSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aboveQ <= '0;
      leftQ  <= '0;
      modeQ  <= MODE_VERT;
      upQ    <= 1'b0;
      lfQ    <= 1'b0;
    end else if (stb.latch) begin
      aboveQ <= aboveIn;
      leftQ  <= leftColIn;
      modeQ  <= modeIn;
      upQ    <= upperIn;
      lfQ    <= leftIn;
    end
  end

  always_comb begin
    sumAbove = '0;
    sumLeft  = '0;
    for (int i = 0; i < GRID_N; i++) begin
      sumAbove = sumAbove + SUM_W'(aboveQ[i*SAMPLE_W +: SAMPLE_W]);
      sumLeft  = sumLeft  + SUM_W'(leftQ[i*SAMPLE_W +: SAMPLE_W]);
    end
  end

  always_comb begin
    case ({upQ, lfQ})
      2'b11:   dcVal = SAMPLE_W'((sumAbove + sumLeft + SUM_W'(GRID_N)) >> (LOG_N + 1));
      2'b10:   dcVal = SAMPLE_W'((sumAbove + SUM_W'(GRID_N / 2)) >> LOG_N);
      2'b01:   dcVal = SAMPLE_W'((sumLeft + SUM_W'(GRID_N / 2)) >> LOG_N);
      default: dcVal = SAMPLE_W'(1 << (SAMPLE_W - 1));
    endcase
  end

  assign leftSel = leftQ[stb.row*SAMPLE_W +: SAMPLE_W];

  for (genvar c = 0; c < GRID_N; c++) begin : g_col
    assign rowData[c*SAMPLE_W +: SAMPLE_W] =
        (modeQ == MODE_VERT) ? aboveQ[c*SAMPLE_W +: SAMPLE_W] :
        (modeQ == MODE_HORZ) ? leftSel : dcVal;
  end
endmodule

// File: rtl/intra_fill16.sv
module intra_fill16
  import intra_fill_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [1:0]                 mode,
  input  logic                       upperOk,
  input  logic                       leftOk,
  input  logic [GRID_N*SAMPLE_W-1:0] aboveRow,
  input  logic [GRID_N*SAMPLE_W-1:0] leftCol,
  output logic                       rowValid,
  output logic [ROW_W-1:0]           rowIdx,
  output logic                       rowLast,
  output logic [GRID_N*SAMPLE_W-1:0] rowData,
  output logic                       badMode
);
  fillStrobe_t stb;

  intra_fill_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mode     (mode),
    .stb      (stb),
    .rowValid (rowValid),
    .rowIdx   (rowIdx),
    .rowLast  (rowLast),
    .badMode  (badMode)
  );

  intra_fill_dp #(.SAMPLE_W(SAMPLE_W)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .modeIn    (mode),
    .upperIn   (upperOk),
    .leftIn    (leftOk),
    .aboveIn   (aboveRow),
    .leftColIn (leftCol),
    .rowData   (rowData)
  );
endmodule

// File: rtl/intra_fill16_chk.sv
module intra_fill16_chk
  import intra_fill_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       mode,
  input logic             rowValid,
  input logic [ROW_W-1:0] rowIdx,
  input logic             rowLast,
  input logic             badMode
);
  // R6
  last_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowLast |-> (rowValid && rowIdx == ROW_W'(GRID_N - 1)));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && !rowLast) |=> (rowValid && rowIdx == ROW_W'($past(rowIdx) + 1'b1)));

  // R6
  run_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !rowValid && mode != MODE_PLANE) |=> (rowValid && rowIdx == '0));

  // R9
  run_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowLast |=> !rowValid);

  // R7
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !rowValid && mode == MODE_PLANE) |=> (badMode && !rowValid));

  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    badMode |=> !rowValid);
endmodule

bind intra_fill16 intra_fill16_chk chkI (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .mode     (mode),
  .rowValid (rowValid),
  .rowIdx   (rowIdx),
  .rowLast  (rowLast),
  .badMode  (badMode)
);

// File: tb/intra_fill16_test.sv
module intra_fill16_test;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          upperOk = 1'b0;
  logic          leftOk = 1'b0;
  logic [DW-1:0] aboveRow = '0;
  logic [DW-1:0] leftCol = '0;
  logic          rowValid;
  logic [3:0]    rowIdx;
  logic          rowLast;
  logic [DW-1:0] rowData;
  logic          badMode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  intra_fill16 uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .upperOk(upperOk), .leftOk(leftOk), .aboveRow(aboveRow), .leftCol(leftCol),
    .rowValid(rowValid), .rowIdx(rowIdx), .rowLast(rowLast),
    .rowData(rowData), .badMode(badMode)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(input logic [DW-1:0] v, input int i);
    return v[8*i +: 8];
  endfunction

  function automatic logic [7:0] flatVal(input logic u, input logic l,
                                         input logic [DW-1:0] ab, input logic [DW-1:0] lc);
    int sa = 0;
    int sl = 0;
    for (int i = 0; i < 16; i++) begin
      sa += byteOf(ab, i);
      sl += byteOf(lc, i);
    end
    if (u && l) return 8'((sa + sl + 16) / 32);
    if (u) return 8'((sa + 8) / 16);
    if (l) return 8'((sl + 8) / 16);
    return 8'd128;
  endfunction

  function automatic logic [DW-1:0] expRow(input logic [1:0] m, input int y,
      input logic u, input logic l, input logic [DW-1:0] ab, input logic [DW-1:0] lc);
    logic [DW-1:0] r;
    for (int x = 0; x < 16; x++) begin
      if (m == 2'd0) r[8*x +: 8] = byteOf(ab, x);
      else if (m == 2'd1) r[8*x +: 8] = byteOf(lc, y);
      else r[8*x +: 8] = flatVal(u, l, ab, lc);
    end
    return r;
  endfunction

  // One prediction run; scramble changes inputs after capture (R8),
  // poke issues a start mid-run (R9).
  task automatic runPred(input logic [1:0] m, input logic u, input logic l,
                         input logic [DW-1:0] ab, input logic [DW-1:0] lc,
                         input bit scramble, input bit poke, input string req);
    @(negedge clk);
    mode = m; upperOk = u; leftOk = l; aboveRow = ab; leftCol = lc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      aboveRow = ~ab; leftCol = {lc[7:0], lc[DW-1:8]} ^ {16{8'h5a}};
      mode = 2'd2 - m; upperOk = ~u; leftOk = ~l;
    end
    for (int y = 0; y < 16; y++) begin
      chk(rowValid && rowIdx == 4'(y) && rowLast == (y == 15), "R6", "row strobe",
          DW'({rowValid, rowIdx, rowLast}), DW'({1'b1, 4'(y), (y == 15)}));
      chk(rowData == expRow(m, y, u, l, ab, lc), req, $sformatf("row %0d data", y),
          rowData, expRow(m, y, u, l, ab, lc));
      if (scramble && y == 0) chk(rowData == expRow(m, 0, u, l, ab, lc), "R8",
          "captured inputs", rowData, expRow(m, 0, u, l, ab, lc));
      if (poke) begin
        start = (y == 5);
        mode = (y == 5) ? 2'd1 : mode;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(!rowValid, poke ? "R9" : "R6", "idle after row 15", DW'(rowValid), '0);
  endtask

  task automatic testReset();
    chk(!rowValid && !rowLast && !badMode, "R10", "reset outputs",
        DW'({rowValid, rowLast, badMode}), '0);
  endtask

  task automatic testPlaneReject();
    @(negedge clk);
    mode = 2'd3; upperOk = 1'b1; leftOk = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(badMode && !rowValid, "R7", "flag raised, no row",
        DW'({badMode, rowValid}), DW'(2'b10));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!rowValid && !badMode, "R7", "quiet after reject",
          DW'({badMode, rowValid}), '0);
    end
  endtask

  logic [DW-1:0] ramp;
  logic [DW-1:0] mixA;
  logic [DW-1:0] mixL;

  initial begin
    for (int i = 0; i < 16; i++) begin
      ramp[8*i +: 8] = 8'(i + 1);
      mixA[8*i +: 8] = 8'(17 * i + 3);
      mixL[8*i +: 8] = 8'(250 - 9 * i);
    end
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R1 vertical, inputs disturbed during run (R8)
    runPred(2'd0, 1'b1, 1'b0, mixA, ramp, 1'b1, 1'b0, "R1");
    // R2 horizontal, stray start mid-run (R9)
    runPred(2'd1, 1'b0, 1'b1, ramp, mixL, 1'b0, 1'b1, "R2");
    runPred(2'd1, 1'b1, 1'b1, mixA, ramp, 1'b1, 1'b0, "R2");
    // R3 both neighbours
    runPred(2'd2, 1'b1, 1'b1, mixA, mixL, 1'b0, 1'b0, "R3");
    // R11 saturating samples
    runPred(2'd2, 1'b1, 1'b1, {16{8'hff}}, {16{8'hff}}, 1'b0, 1'b0, "R11");
    // R4 one side only
    runPred(2'd2, 1'b1, 1'b0, ramp, {16{8'hff}}, 1'b0, 1'b0, "R4");
    runPred(2'd2, 1'b0, 1'b1, {16{8'hff}}, mixL, 1'b1, 1'b0, "R4");
    // R5 no neighbours
    runPred(2'd2, 1'b0, 1'b0, mixA, mixL, 1'b0, 1'b0, "R5");
    // R7 plane code rejected
    testPlaneReject();
    runPred(2'd0, 1'b0, 1'b0, ramp, mixL, 1'b0, 1'b0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule